// File: doc/BRIEF.md
# Serial Port Interrupt Status Collector

This block gathers fourteen single-cycle event pulses produced by a serial port's transmit path, receive path and modem-control logic, and latches each one into a sticky status bit. A companion enable register selects which of the latched events may raise the one active-high, level-sensitive interrupt line. Software finds out what happened by reading the status word, and acknowledges events by writing ones to the bits it has serviced. Writing back the word it just read therefore clears exactly the events it saw, and any event that arrives in the meantime is left pending.

A small word-addressed register port gives access to the status word, the enable word and a group-control word. Through the group-control word, software can switch all receive-class or all transmit-class enables on or off in a single write. It does not need to read the enable word, modify it and write it back. The event sources themselves sit outside this block.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the status word, the enable word and the interrupt output are all zero.
- R2: A pulse on event input i sets status bit i on the next clock edge, whatever the enable word holds. Status bits never clear on their own. Input index equals status bit index: 0 tx data empty, 1 rx data full, 2 tx almost empty, 3 tx empty, 4 rx almost full, 5 rx full, 6 tx underrun, 7 rx overrun, 8 parity error, 9 frame error, 10 cts toggle, 11 rx timeout, 12 break done, 13 bus error.
- R3: A write to word 0 (status) clears every status bit whose data bit is one and leaves the bits written as zero unchanged.
- R4: If an event pulses in the same cycle as a write that clears its bit, the bit remains set.
- R5: The interrupt output is a register that takes the OR over all bits of status AND enable. It follows a change in status or enable one clock later, and it stays high for as long as an enabled bit is pending.
- R6: A write to word 1 (enable) loads data bits 13:0. Reading word 1 returns them, with bits above 13 read as zero.
- R7: A write to word 2 (group control) changes only the enables of one group. Data bit 0 sets the receive group (bits 4, 5, 7, 8, 9, 11), bit 1 clears it, bit 2 sets the transmit group (bits 2, 3, 6) and bit 3 clears it. When set and clear are both given for the same group, clear wins. Enables outside the groups keep their value.
- R8: Reads of word 2 and of any unmapped word return zero. Writes to unmapped words change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 14 | One-cycle event pulses, one per status bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Level-high interrupt request |

## Verification
The assertions assume that each event input is a clean pulse sampled at the clock edge. They also assume that a register write lasts exactly one cycle, with its address and data stable in that cycle. The bench meets these assumptions by changing every input just after a rising edge and holding each write for a single cycle. The stimulus deliberately lines up an event pulse with a clearing write to the same bit. It also gives set and clear together for one group, so the priority rules are exercised inside those assumptions and not around them.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int NUM_SRC = 14;

    // event classes that software may mask as a unit
    localparam logic [NUM_SRC-1:0] RX_GROUP = 14'h0BB0; // bits 4,5,7,8,9,11
    localparam logic [NUM_SRC-1:0] TX_GROUP = 14'h004C; // bits 2,3,6

    // word indices of the register port
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GROUP  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // bit positions inside the group-control word
    localparam int GRP_RX_SET = 0;
    localparam int GRP_RX_CLR = 1;
    localparam int GRP_TX_SET = 2;
    localparam int GRP_TX_CLR = 3;

    typedef struct packed {
        logic rx_set;
        logic rx_clr;
        logic tx_set;
        logic tx_clr;
    } grp_op_t;

    typedef struct packed {
        logic stat_wr;
        logic en_wr;
        logic grp_wr;
    } bus_strobe_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_stat_pkg::*;
#(
    parameter int N      = NUM_SRC,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N-1:0]      status_q,
    input  logic [N-1:0]      enable_q,
    output bus_strobe_t       strobe,
    output logic [N-1:0]      wr_bits,
    output grp_op_t           grp_op,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SEL_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(SEL_ENABLE);
    localparam logic [ADDR_W-1:0] A_GROUP  = ADDR_W'(SEL_GROUP);

    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:N];

    always_comb begin
        strobe.stat_wr = bus_wr && (bus_addr == A_STATUS);
        strobe.en_wr   = bus_wr && (bus_addr == A_ENABLE);
        strobe.grp_wr  = bus_wr && (bus_addr == A_GROUP);
        wr_bits        = bus_wdata[N-1:0];
        grp_op.rx_set  = bus_wdata[GRP_RX_SET];
        grp_op.rx_clr  = bus_wdata[GRP_RX_CLR];
        grp_op.tx_set  = bus_wdata[GRP_TX_SET];
        grp_op.tx_clr  = bus_wdata[GRP_TX_CLR];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) begin
            bus_rdata[N-1:0] = status_q;
        end else if (bus_addr == A_ENABLE) begin
            bus_rdata[N-1:0] = enable_q;
        end
    end

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status_q
);

    typedef struct packed {
        logic [N-1:0] status;
    } st_t;

    st_t          st_d;
    st_t          st_q;
    logic [N-1:0] bit_next;

    // one sticky cell per source; a fresh event beats a same-cycle clear
    for (genvar gi = 0; gi < N; gi++) begin : g_cell
        logic kill;
        assign kill         = clr_en && clr_bits[gi];
        assign bit_next[gi] = evt[gi] || (st_q.status[gi] && !kill);
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = bit_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;

endmodule

// File: rtl/irq_enable_core.sv
module irq_enable_core
    import irq_stat_pkg::*;
#(
    parameter int           N       = NUM_SRC,
    parameter logic [N-1:0] RX_MASK = RX_GROUP,
    parameter logic [N-1:0] TX_MASK = TX_GROUP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         grp_en,
    input  logic [N-1:0] wr_bits,
    input  grp_op_t      grp_op,
    output logic [N-1:0] enable_q
);

    typedef struct packed {
        logic [N-1:0] enable;
    } en_t;

    en_t en_d;
    en_t en_q;

    always_comb begin
        en_d = en_q;
        if (load_en) begin
            en_d.enable = wr_bits;
        end else if (grp_en) begin
            if (grp_op.rx_set) en_d.enable = en_d.enable | RX_MASK;
            if (grp_op.tx_set) en_d.enable = en_d.enable | TX_MASK;
            if (grp_op.rx_clr) en_d.enable = en_d.enable & ~RX_MASK;
            if (grp_op.tx_clr) en_d.enable = en_d.enable & ~TX_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enable_q = en_q.enable;

endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
    parameter int N       = 14,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_q,
    input  logic [N-1:0] enable_q,
    output logic         irq
);

    logic pend;
    assign pend = |(status_q & enable_q);

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic line;
        } ln_t;

        ln_t ln_d;
        ln_t ln_q;

        always_comb begin
            ln_d      = ln_q;
            ln_d.line = pend;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ln_q <= '0;
            end else begin
                ln_q <= ln_d;
            end
        end

        assign irq = ln_q.line;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign irq        = pend;
    end

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  evt_pulse,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);

    logic [NUM_SRC-1:0] status_vec;
    logic [NUM_SRC-1:0] enable_vec;
    logic [NUM_SRC-1:0] wr_bits;
    bus_strobe_t        strobe;
    grp_op_t            grp_op;

    irq_bus_decode #(
        .N      (NUM_SRC),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q  (status_vec),
        .enable_q  (enable_vec),
        .strobe    (strobe),
        .wr_bits   (wr_bits),
        .grp_op    (grp_op),
        .bus_rdata (bus_rdata)
    );

    irq_status_core #(
        .N (NUM_SRC)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr_en   (strobe.stat_wr),
        .clr_bits (wr_bits),
        .status_q (status_vec)
    );

    irq_enable_core #(
        .N       (NUM_SRC),
        .RX_MASK (RX_GROUP),
        .TX_MASK (TX_GROUP)
    ) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (strobe.en_wr),
        .grp_en   (strobe.grp_wr),
        .wr_bits  (wr_bits),
        .grp_op   (grp_op),
        .enable_q (enable_vec)
    );

    irq_line_drive #(
        .N       (NUM_SRC),
        .REG_OUT (1'b1)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_vec),
        .enable_q (enable_vec),
        .irq      (irq)
    );

endmodule

// File: rtl/irq_stat_unit_chk.sv
module irq_stat_unit_chk #(
    parameter int N      = 14,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N-1:0]      status,
    input logic [N-1:0]      enable,
    input logic              irq
);

    logic         stat_write;
    logic [N-1:0] clr_expect;
    logic         pend;

    assign stat_write = bus_wr && (bus_addr == '0);
    assign clr_expect = bus_wdata[N-1:0] & ~evt;
    assign pend       = |(status & enable);

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt))); // R2

    AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_write |=> ((status & $past(status)) == $past(status))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_write |=> ((status & $past(clr_expect)) == '0)); // R3

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_write && (|evt)) |=> ((status & $past(evt)) == $past(evt))); // R4

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pend))); // R5

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(enable)); // R6

endmodule

bind irq_stat_unit irq_stat_unit_chk #(
    .N      (irq_stat_pkg::NUM_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_pulse),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status_vec),
    .enable    (enable_vec),
    .irq       (irq)
);

// File: tb/irq_stat_unit_tb.sv
module irq_stat_unit_tb;

    localparam int N      = 14;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int WD_MAX = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      evt_pulse = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    always #2.5 clk = ~clk;

    irq_stat_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cycles = 0;
    bit          done = 1'b0;
    logic [13:0] m_stat = '0;
    logic [13:0] m_en = '0;

    localparam logic [13:0] RXM = 14'h0BB0;
    localparam logic [13:0] TXM = 14'h004C;

    // monitor: compares one expected item per cycle, away from the edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = sb_q.pop_front();
            got = it.is_irq ? {31'd0, irq} : bus_rdata;
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_MAX && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WD_MAX);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // driver: applies one cycle of stimulus and updates the reference model
    task automatic drive(input bit wr, input logic [3:0] a, input logic [31:0] d,
                         input logic [13:0] ev);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        evt_pulse = ev;
        if (wr && a == 4'd0) m_stat = m_stat & ~d[13:0];
        if (wr && a == 4'd1) m_en = d[13:0];
        if (wr && a == 4'd2) begin
            if (d[0]) m_en = m_en | RXM;
            if (d[2]) m_en = m_en | TXM;
            if (d[1]) m_en = m_en & ~RXM;
            if (d[3]) m_en = m_en & ~TXM;
        end
        m_stat = m_stat | ev;
        cyc();
        bus_wr    = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string r);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.req    = r;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic exp_irq(input logic e, input string r);
        item_t it;
        cyc();
        it.is_irq = 1'b1;
        it.exp    = {31'd0, e};
        it.req    = r;
        sb_q.push_back(it);
        cyc();
    endtask

    initial begin
        repeat (3) cyc();
        // R1: reset values
        exp_rd(4'd0, 32'h0, "R1 status");
        exp_rd(4'd1, 32'h0, "R1 enable");
        exp_irq(1'b0, "R1 irq");
        rst_n = 1'b1;
        cyc();
        exp_rd(4'd0, 32'h0, "R1 status after release");

        // R2: events latch regardless of enable
        drive(1'b0, 4'd0, 32'h0, 14'h0001);
        exp_rd(4'd0, {18'd0, m_stat}, "R2 bit0");
        exp_irq(1'b0, "R5 masked");
        drive(1'b0, 4'd0, 32'h0, 14'h2080);
        repeat (4) cyc();
        exp_rd(4'd0, 32'h0000_2081, "R2 sticky bits 13 7 0");

        // R6: enable width
        drive(1'b1, 4'd1, 32'hFFFF_FFFF, 14'h0);
        exp_rd(4'd1, 32'h0000_3FFF, "R6 enable readback");
        exp_irq(1'b1, "R5 enabled pending");

        // R3: write one clears, write zero keeps
        drive(1'b1, 4'd0, 32'h0000_0080, 14'h0);
        exp_rd(4'd0, 32'h0000_2001, "R3 clear bit7");
        drive(1'b1, 4'd0, 32'h0, 14'h0);
        exp_rd(4'd0, 32'h0000_2001, "R3 zero write");

        // R4: event beats same-cycle clear
        drive(1'b1, 4'd0, 32'h0000_2001, 14'h0001);
        exp_rd(4'd0, 32'h0000_0001, "R4 collision");
        drive(1'b1, 4'd0, 32'h0000_0001, 14'h0);
        exp_rd(4'd0, 32'h0, "R3 all clear");
        exp_irq(1'b0, "R5 drops after clear");

        // R7: group control
        drive(1'b1, 4'd1, 32'h0000_0001, 14'h0);
        drive(1'b1, 4'd2, 32'h0000_0001, 14'h0);
        exp_rd(4'd1, 32'h0000_0BB1, "R7 rx set");
        drive(1'b1, 4'd2, 32'h0000_0004, 14'h0);
        exp_rd(4'd1, 32'h0000_0BFD, "R7 tx set");
        drive(1'b1, 4'd2, 32'h0000_0002, 14'h0);
        exp_rd(4'd1, 32'h0000_004D, "R7 rx clear");
        drive(1'b1, 4'd2, 32'h0000_0003, 14'h0);
        exp_rd(4'd1, 32'h0000_004D, "R7 clear wins");
        drive(1'b1, 4'd2, 32'h0000_0008, 14'h0);
        exp_rd(4'd1, {18'd0, m_en}, "R7 tx clear");
        drive(1'b1, 4'd2, 32'h0000_0004, 14'h0);

        // R5 through the transmit group
        drive(1'b0, 4'd0, 32'h0, 14'h0800);
        exp_irq(1'b0, "R5 rx event masked");
        drive(1'b0, 4'd0, 32'h0, 14'h0040);
        exp_irq(1'b1, "R5 tx underrun raises");
        exp_irq(1'b1, "R5 level holds");

        // R8: unmapped and group reads, ignored writes
        exp_rd(4'd2, 32'h0, "R8 group reads zero");
        exp_rd(4'd3, 32'h0, "R8 unmapped reads zero");
        drive(1'b1, 4'd3, 32'hFFFF_FFFF, 14'h0);
        drive(1'b1, 4'd9, 32'hFFFF_FFFF, 14'h0);
        exp_rd(4'd0, 32'h0000_0840, "R8 status untouched");
        exp_rd(4'd1, {18'd0, m_en}, "R8 enable untouched");

        repeat (2) cyc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule